// File: doc/BRIEF.md
# Bus Ownership Semaphore

This block decides which of two agents, the host processor or an embedded microcontroller, may drive a shared SMBus controller at any moment. Both agents share the controller's register space. Neither agent may touch the controller until it holds ownership.

The host works through one byte-wide control register. Writing 1 to the request bit asks for the bus. Reading the same bit back returns 1 only while the host is the owner. Writing 1 to the release bit gives ownership up. Software polls the request bit until it reads 1 and handles its own retry timing. The microcontroller uses two single-cycle strobes, one to request and one to release. It receives a grant level in return.

A request that cannot be served right away is held as pending. It is granted at the clock edge where the current owner releases. When both agents want a free bus in the same cycle, the microcontroller is served first. The asynchronous active-low reset is released synchronously inside the block.

Top module: `bus_own_sema`

## Requirements
- R1: After reset neither agent owns the bus. `host_grant`, `mcu_grant` and `host_rdata` are all 0.
- R2: A host write with bit 4 of `host_wdata` set, while the bus is free and the microcontroller is not requesting, makes `host_grant` 1 from the next clock edge.
- R3: `host_rdata` bit 4 equals the host's ownership. Bit 5 and every other bit always read 0. While the microcontroller owns the bus, bit 4 reads 0.
- R4: A host write with bit 5 set, while the host owns the bus, clears `host_grant` at the next edge.
- R5: A release by an agent that does not own the bus has no effect on ownership. This covers a host write with bit 5 set and an `mcu_rel` strobe.
- R6: When the bus is free and both agents request in the same cycle, the microcontroller is granted at the next edge. The host request stays pending.
- R7: A request made while the other agent owns the bus stays pending. It is granted at the same edge where the owner releases.
- R8: At most one of `host_grant` and `mcu_grant` is 1 in any cycle.
- R9: A request from an agent that already owns the bus changes nothing. An `mcu_rel` strobe while the microcontroller owns the bus frees it at the next edge.
- R10: A host write with bits 4 and 5 both 0 has no effect on ownership, whatever the other bits hold.
- R11: A host write that sets bits 4 and 5 together while the host owns the bus releases and re-requests. The host keeps the bus unless the microcontroller is requesting or pending, in which case the microcontroller takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe to the control register |
| host_wdata | input | 8 | Host write data. Bit 4 requests, bit 5 releases |
| host_rdata | output | 8 | Control register read value. Bit 4 is the host's ownership |
| mcu_req | input | 1 | Microcontroller request strobe |
| mcu_rel | input | 1 | Microcontroller release strobe |
| host_grant | output | 1 | Host owns the controller |
| mcu_grant | output | 1 | Microcontroller owns the controller |

## Verification
The two functions that can coincide are the host's request and the microcontroller's request. A release by one side can also coincide with a new request from the other. The bench provokes these cases with directed writes and strobes in the same clock cycle. It then runs a long random stream in which overlaps are frequent. A behavioural model keeps an owner code and two pending flags. It applies each release before arbitration and gives the microcontroller priority. Every cycle it predicts both grants and the read value, and these are compared against the design.

// File: rtl/sema_pkg.sv
package sema_pkg;
  // requester index; a higher index wins a same-cycle tie
  localparam int unsigned AGENTS   = 2;
  localparam int unsigned IDX_HOST = 0;
  localparam int unsigned IDX_MCU  = 1;
  typedef logic [AGENTS-1:0] agent_vec_t;
endpackage

// File: rtl/sema_rst_sync.sv
module sema_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sema_host_port.sv
module sema_host_port #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REQ_POS = 4,
  parameter int unsigned REL_POS = 5
) (
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              owns,
  output logic              req,
  output logic              rel,
  output logic [DATA_W-1:0] rdata
);
  assign req = wr & wdata[REQ_POS];
  assign rel = wr & wdata[REL_POS];

  always_comb begin
    rdata          = '0;
    rdata[REQ_POS] = owns;
  end
endmodule

// File: rtl/sema_core.sv
module sema_core
  import sema_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  agent_vec_t req,
  input  agent_vec_t rel,
  output agent_vec_t owner
);
  agent_vec_t own_q, own_d, pend_q, pend_d, held, want;
  logic       freed;

  // a release counts only from the agent that owns the bus
  assign freed = |(own_q & rel);
  assign held  = freed ? '0 : own_q;

  for (genvar i = 0; i < AGENTS; i++) begin : g_want
    assign want[i] = (pend_q[i] | req[i]) & ~held[i];
  end

  always_comb begin
    own_d = held;
    if (held == '0) begin
      if (want[IDX_MCU])       own_d[IDX_MCU]  = 1'b1;
      else if (want[IDX_HOST]) own_d[IDX_HOST] = 1'b1;
    end
    pend_d = want & ~own_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      pend_q <= '0;
    end else begin
      own_q  <= own_d;
      pend_q <= pend_d;
    end
  end

  assign owner = own_q;
endmodule

// File: rtl/bus_own_sema.sv
module bus_own_sema
  import sema_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REQ_POS = 4,
  parameter int unsigned REL_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mcu_req,
  input  logic              mcu_rel,
  output logic              host_grant,
  output logic              mcu_grant
);
  logic       rst_sync_n, h_req, h_rel;
  agent_vec_t req_v, rel_v, owner;

  sema_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sema_host_port #(.DATA_W(DATA_W), .REQ_POS(REQ_POS), .REL_POS(REL_POS)) u_port (
    .wr(host_wr), .wdata(host_wdata), .owns(owner[IDX_HOST]),
    .req(h_req), .rel(h_rel), .rdata(host_rdata)
  );

  always_comb begin
    req_v           = '0;
    rel_v           = '0;
    req_v[IDX_HOST] = h_req;
    rel_v[IDX_HOST] = h_rel;
    req_v[IDX_MCU]  = mcu_req;
    rel_v[IDX_MCU]  = mcu_rel;
  end

  sema_core u_core (
    .clk(clk), .rst_n(rst_sync_n), .req(req_v), .rel(rel_v), .owner(owner)
  );

  assign host_grant = owner[IDX_HOST];
  assign mcu_grant  = owner[IDX_MCU];
endmodule

// File: rtl/sema_chk.sv
module sema_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REQ_POS = 4,
  parameter int unsigned REL_POS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              mcu_req,
  input logic              mcu_rel,
  input logic              host_grant,
  input logic              mcu_grant
);
  logic free_bus, h_rq, h_rl;
  assign free_bus = !host_grant && !mcu_grant;
  assign h_rq     = host_wr && host_wdata[REQ_POS];
  assign h_rl     = host_wr && host_wdata[REL_POS];

  // R8
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_grant, mcu_grant}));

  // R2
  host_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_bus && h_rq && !mcu_req |=> host_grant);

  // R6
  tie_mcu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_bus && h_rq && mcu_req |=> mcu_grant);

  // R4
  host_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant && h_rl && !h_rq |=> !host_grant);

  // R5
  stray_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_grant && h_rl && !mcu_rel |=> mcu_grant);

  // R3
  rd_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[REQ_POS] == host_grant && !host_rdata[REL_POS]);
endmodule

bind bus_own_sema sema_chk #(.DATA_W(DATA_W), .REQ_POS(REQ_POS), .REL_POS(REL_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .mcu_req(mcu_req), .mcu_rel(mcu_rel),
  .host_grant(host_grant), .mcu_grant(mcu_grant)
);

// File: tb/sim_bus_own_sema.sv
`timescale 1ns/1ps
module sim_bus_own_sema;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       mcu_req = 1'b0;
  logic       mcu_rel = 1'b0;
  logic       host_grant, mcu_grant;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  // model: 0 free, 1 host, 2 mcu
  int m_owner = 0;
  bit m_hp = 0, m_mp = 0;

  always #4 clk = ~clk;

  bus_own_sema u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mcu_req(mcu_req), .mcu_rel(mcu_rel),
    .host_grant(host_grant), .mcu_grant(mcu_grant)
  );

  task automatic check(input string tag);
    logic [7:0] exp_rd;
    exp_rd = (m_owner == 1) ? 8'h10 : 8'h00;
    checks++;
    if (host_grant !== (m_owner == 1) || mcu_grant !== (m_owner == 2) || host_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s: host_grant=%b mcu_grant=%b rdata=%h expected %b %b %h",
               tag, host_grant, mcu_grant, host_rdata, m_owner == 1, m_owner == 2, exp_rd);
    end
  endtask

  task automatic model_step(input bit hw, input logic [7:0] wd, input bit mr, input bit ml);
    bit hreq, hrel, ph, pm;
    int of;
    hreq = hw && wd[4];
    hrel = hw && wd[5];
    of = m_owner;
    if ((m_owner == 1 && hrel) || (m_owner == 2 && ml)) of = 0;
    ph = (m_hp || hreq) && of != 1;
    pm = (m_mp || mr) && of != 2;
    if (of == 0) begin
      if (pm) begin of = 2; pm = 0; end
      else if (ph) begin of = 1; ph = 0; end
    end
    m_owner = of; m_hp = ph; m_mp = pm;
  endtask

  // one cycle: check at the falling edge, then drive inputs for the next rising edge
  task automatic cyc(input string tag, input bit hw, input logic [7:0] wd, input bit mr, input bit ml);
    @(negedge clk);
    check(tag);
    host_wr = hw; host_wdata = wd; mcu_req = mr; mcu_rel = ml;
    model_step(hw, wd, mr, ml);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    idle("R1", 4);
    // R2: host takes free bus, polls while owning (R9)
    cyc("R2", 1, 8'h10, 0, 0);
    cyc("R2", 1, 8'h10, 0, 0);
    // R10: writes without bits 4/5
    cyc("R10", 1, 8'hCF, 0, 0);
    cyc("R10", 1, 8'h00, 0, 0);
    // R5: mcu release while host owns
    cyc("R5", 0, 8'h00, 0, 1);
    // R4: host release
    cyc("R4", 1, 8'h20, 0, 0);
    idle("R4", 1);
    // R5: host release on a free bus
    cyc("R5", 1, 8'h20, 0, 0);
    idle("R5", 1);
    // R6: tie, mcu wins, host pending
    cyc("R6", 1, 8'h10, 1, 0);
    // R3: host polls while mcu owns, reads 0; stray host release (R5)
    cyc("R3", 1, 8'h10, 0, 0);
    cyc("R5", 1, 8'h20, 0, 0);
    // R9: mcu re-request changes nothing
    cyc("R9", 0, 8'h00, 1, 0);
    idle("R3", 2);
    // R7: mcu release hands over to pending host
    cyc("R7", 0, 8'h00, 0, 1);
    idle("R7", 1);
    // R7: mcu requests while host owns, gets it on host release
    cyc("R7", 0, 8'h00, 1, 0);
    idle("R7", 2);
    cyc("R7", 1, 8'h20, 0, 0);
    idle("R7", 1);
    // R9: mcu release frees
    cyc("R9", 0, 8'h00, 0, 1);
    idle("R9", 1);
    // R11: release+request while host owns, nobody else
    cyc("R11", 1, 8'h10, 0, 0);
    cyc("R11", 1, 8'h30, 0, 0);
    idle("R11", 1);
    // R11: release+request with mcu requesting in the same cycle
    cyc("R11", 1, 8'h30, 1, 0);
    idle("R11", 1);
    cyc("R11", 0, 8'h00, 0, 1);
    idle("R11", 1);
    // R8: random overlap stream
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cyc("R8", ($urandom % 3) == 0, d, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    idle("R8", 2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule